// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Shadowed Settings

This block is a bank of up to four pulse-width modulation channels. Software reaches it through a word-wide register port with a valid/write/address/data handshake. Each channel has four registers: a prescaler, a period length (modulus), a high-time length (duty) and an enable bit. Each channel counts source-clock cycles in steps of (prescaler+1) cycles and drives one active-high output.

Modulus and duty writes first land in shadow registers. A duty write commits the pair, and the active copy changes only at the end of the running period. This means a period never mixes old and new settings. Clearing the enable bit stops a channel at once, in mid-period. Setting it again starts a fresh period from count zero with the newest committed pair.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register of every channel reads zero and every output is low.
- R2: The register of channel c sits at byte address (c<<5)+offset. The offsets are 0x00 for the prescaler (8 bits), 0x04 for the modulus (8 bits), 0x08 for the duty (16 bits) and 0x18 for the enable (bit 0). A read returns the last value written, with bits above the field width reading zero. The modulus and duty reads return the shadow values.
- R3: Any other offset, and any channel index at or above NUM_CH, reads zero and ignores writes.
- R4: An enabled channel repeats a period of (P+1)*M source cycles and is high for the first (P+1)*min(D,M) of them. A modulus of 0 acts as 1.
- R5: With D >= M the output stays high for the whole period. With D = 0 it stays low.
- R6: A modulus write without a following duty write never changes the output.
- R7: A duty write commits the shadow modulus and duty together. The running period finishes with the old pair, and the new pair starts with the next period.
- R8: Writing 0 to the enable bit drives the output low from the next cycle, with no wait for the period to end. Setting the enable bit on a stopped channel starts at count zero with the newest committed pair, including one committed while the channel was stopped.
- R9: When a duty write falls in the last cycle of a period, the commit is not applied at that boundary. It waits for the following boundary.
- R10: Channels run independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for the bus and the counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address: channel index in [6:5], register offset in [4:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read request |
| pwm_out | output | NUM_CH | One active-high output per channel |

## Verification
The interesting collision is a duty write that lands in the last cycle of a running period. In that cycle the boundary logic wants to load the active pair and clear the commit flag, while the bus wants to set the flag. The bench counts cycles from a known enable and places the duty write exactly on that edge. It then checks the output cycle by cycle: the next period must still use the old duty, and the new duty must show only one period later. A second collision, a disable arriving inside the high phase, is judged by a low output in the very next cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRE_W  = 8;
  localparam int MOD_W  = 8;
  localparam int DUTY_W = 16;
  localparam int OFF_W  = 5;
  localparam int MAX_CH = 4;
  localparam int CH_W   = $clog2(MAX_CH);
  localparam int ADDR_W = OFF_W + CH_W;
  localparam int WORD_W = 32;

  localparam logic [OFF_W-1:0] OFF_PRESC = 5'h00;
  localparam logic [OFF_W-1:0] OFF_MOD   = 5'h04;
  localparam logic [OFF_W-1:0] OFF_DUTY  = 5'h08;
  localparam logic [OFF_W-1:0] OFF_EN    = 5'h18;

  typedef logic [PRE_W-1:0]  presc_t;
  typedef logic [MOD_W-1:0]  mod_t;
  typedef logic [DUTY_W-1:0] duty_t;

  // A modulus of zero behaves as a one-step period.
  function automatic mod_t eff_mod(mod_t m);
    return (m == '0) ? mod_t'(1) : m;
  endfunction

  // Output level for a given step index within the period.
  function automatic logic level_high(mod_t step, duty_t duty);
    return duty_t'(step) < duty;
  endfunction
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [OFF_W-1:0]  off,
  input  logic [DUTY_W-1:0] wdata,
  input  logic              period_end,
  output logic              en,
  output presc_t            presc,
  output mod_t              mod_act,
  output duty_t             duty_act,
  output logic [WORD_W-1:0] rd_val
);
  mod_t  mod_sh;
  duty_t duty_sh;
  logic  pending;

  logic presc_wr, mod_wr, duty_wr, en_wr, start, load;
  assign presc_wr = wr && (off == OFF_PRESC);
  assign mod_wr   = wr && (off == OFF_MOD);
  assign duty_wr  = wr && (off == OFF_DUTY);
  assign en_wr    = wr && (off == OFF_EN);
  assign start    = en_wr && wdata[0] && !en;
  assign load     = pending && (start || period_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc    <= '0;
      mod_sh   <= '0;
      duty_sh  <= '0;
      en       <= 1'b0;
      mod_act  <= '0;
      duty_act <= '0;
      pending  <= 1'b0;
    end else begin
      if (presc_wr) presc   <= wdata[PRE_W-1:0];
      if (mod_wr)   mod_sh  <= wdata[MOD_W-1:0];
      if (duty_wr)  duty_sh <= wdata;
      if (en_wr)    en      <= wdata[0];
      if (load) begin
        mod_act  <= mod_sh;
        duty_act <= duty_sh;
      end
      // A fresh commit outranks the clear from a simultaneous load.
      if (duty_wr)   pending <= 1'b1;
      else if (load) pending <= 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (off)
      OFF_PRESC: rd_val = WORD_W'(presc);
      OFF_MOD:   rd_val = WORD_W'(mod_sh);
      OFF_DUTY:  rd_val = WORD_W'(duty_sh);
      OFF_EN:    rd_val = WORD_W'(en);
      default:   rd_val = '0;
    endcase
  end

  // R7: the active pair moves only at a period end or at a start.
  p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !start) |=> ($stable(mod_act) && $stable(duty_act)));
  // R7: a pending commit with no new duty write is consumed at the boundary.
  p_commit_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && pending && !duty_wr) |=> !pending);
  // R9: a duty write always leaves a commit waiting, even on a boundary.
  p_collide_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    duty_wr |=> pending);
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  presc_t presc,
  input  mod_t   mod_act,
  input  duty_t  duty_act,
  output logic   pwm_o,
  output logic   period_end
);
  presc_t pre_cnt;
  mod_t   per_cnt;
  logic   step;

  assign step       = en && (pre_cnt >= presc);
  assign period_end = step && (per_cnt >= eff_mod(mod_act) - mod_t'(1));
  assign pwm_o      = en && level_high(per_cnt, duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (!en) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (step) begin
      pre_cnt <= '0;
      per_cnt <= period_end ? '0 : per_cnt + mod_t'(1);
    end else begin
      pre_cnt <= pre_cnt + presc_t'(1);
    end
  end

  // R8: a stopped channel holds both counters at zero.
  p_idle_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre_cnt == '0 && per_cnt == '0));
  // R4: the step index never leaves the active period.
  p_step_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (per_cnt < eff_mod(mod_act)));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = MAX_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [CH_W-1:0]   ch_idx;
  logic [OFF_W-1:0]  off;
  logic [WORD_W-1:0] ch_rd [NUM_CH];
  logic [NUM_CH-1:0] sel;
  logic              unused_wdata_hi;

  assign ch_idx          = bus_addr[ADDR_W-1:OFF_W];
  assign off             = bus_addr[OFF_W-1:0];
  assign unused_wdata_hi = &{1'b0, bus_wdata[WORD_W-1:DUTY_W]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic   en, period_end;
    presc_t presc;
    mod_t   mod_act;
    duty_t  duty_act;

    assign sel[c] = bus_valid && (ch_idx == CH_W'(c));

    pwm_chan_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (sel[c] && bus_write),
      .off        (off),
      .wdata      (bus_wdata[DUTY_W-1:0]),
      .period_end (period_end),
      .en         (en),
      .presc      (presc),
      .mod_act    (mod_act),
      .duty_act   (duty_act),
      .rd_val     (ch_rd[c])
    );

    pwm_chan_core u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .presc      (presc),
      .mod_act    (mod_act),
      .duty_act   (duty_act),
      .pwm_o      (pwm_out[c]),
      .period_end (period_end)
    );

    // R8: a stop request silences the output on the very next cycle.
    p_stop_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel[c] && bus_write && off == OFF_EN && !bus_wdata[0]) |=> !pwm_out[c]);
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (sel[c] && !bus_write) bus_rdata = bus_rdata | ch_rd[c];
  end

  initial begin
    // R3: no more channels than the address field can reach.
    p_ch_count_r3: assert (NUM_CH >= 1 && NUM_CH <= MAX_CH);
  end
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int NCH = 3;
  localparam logic [4:0] O_P = 5'h00, O_M = 5'h04, O_D = 5'h08, O_E = 5'h18;

  // {prescale, modulus, duty, period cycles, high cycles}
  localparam logic [47:0] VEC [8] = '{
    {8'd0, 8'd4, 16'd2, 8'd4,  8'd2},
    {8'd1, 8'd5, 16'd3, 8'd10, 8'd6},
    {8'd2, 8'd3, 16'd3, 8'd9,  8'd9},
    {8'd0, 8'd6, 16'd0, 8'd6,  8'd0},
    {8'd3, 8'd2, 16'd7, 8'd8,  8'd8},
    {8'd0, 8'd1, 16'd1, 8'd1,  8'd1},
    {8'd1, 8'd0, 16'd1, 8'd2,  8'd2},
    {8'd4, 8'd8, 16'd1, 8'd40, 8'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] pwm_out;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bwr(input int ch, input logic [4:0] off, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1;
    bus_addr = {ch[1:0], off}; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic brd(input int ch, input logic [4:0] off, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = {ch[1:0], off};
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic setup(input int ch, input int p, input int m, input int d);
    bwr(ch, O_P, 32'(p)); bwr(ch, O_M, 32'(m)); bwr(ch, O_D, 32'(d));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int hi;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    chk("R1 outputs", int'(pwm_out), 0);
    for (int c = 0; c < NCH; c++) begin
      brd(c, O_P, rd); chk("R1 prescale", rd, 0);
      brd(c, O_M, rd); chk("R1 modulus", rd, 0);
      brd(c, O_D, rd); chk("R1 duty", rd, 0);
      brd(c, O_E, rd); chk("R1 enable", rd, 0);
    end

    // R2: readback with field widths, channel separation
    bwr(1, O_P, 32'hFFFF_FFFF); bwr(1, O_M, 32'hFFFF_FFFF);
    bwr(1, O_D, 32'hFFFF_FFFF); bwr(1, O_E, 32'hFFFF_FFFF);
    brd(1, O_P, rd); chk("R2 prescale", rd, 32'hFF);
    brd(1, O_M, rd); chk("R2 modulus", rd, 32'hFF);
    brd(1, O_D, rd); chk("R2 duty", rd, 32'hFFFF);
    brd(1, O_E, rd); chk("R2 enable", rd, 1);
    brd(2, O_P, rd); chk("R2 other channel", rd, 0);
    bwr(1, O_E, 0);

    // R3: undefined offset and absent channel
    bwr(0, O_P, 32'd7);
    bwr(0, 5'h0C, 32'hFFFF_FFFF);
    brd(0, 5'h0C, rd); chk("R3 undefined offset", rd, 0);
    brd(0, O_P, rd); chk("R3 neighbour untouched", rd, 7);
    bwr(3, O_P, 32'hFF); bwr(3, O_E, 1);
    brd(3, O_P, rd); chk("R3 absent channel", rd, 0);
    chk("R3 no output change", int'(pwm_out), 0);

    // R4/R5/R8: table walk
    for (int i = 0; i < 8; i++) begin
      int ch, p, m, d, per, h, first, at_h, before_h;
      ch = i % NCH;
      p = int'(VEC[i][47:40]); m = int'(VEC[i][39:32]); d = int'(VEC[i][31:16]);
      per = int'(VEC[i][15:8]); h = int'(VEC[i][7:0]);
      setup(ch, p, m, d);
      bwr(ch, O_E, 1);
      hi = 0; first = 0; at_h = 0; before_h = 1;
      for (int j = 0; j < 2 * per; j++) begin
        if (j == 0) first = int'(pwm_out[ch]);
        if (j == h) at_h = int'(pwm_out[ch]);
        if (h > 0 && j == h - 1) before_h = int'(pwm_out[ch]);
        hi += int'(pwm_out[ch]);
        tick();
      end
      chk("R4 high cycles over two periods", hi, 2 * h);
      chk("R5 level at period start", first, (d != 0) ? 1 : 0);
      if (h < per) chk("R4 falls after high time", at_h, 0);
      if (h > 0) chk("R4 last high cycle", before_h, 1);
      bwr(ch, O_E, 0);
      chk("R8 stopped output", int'(pwm_out[ch]), 0);
    end

    // R6/R7: modulus-only write, then commit mid-period
    setup(0, 0, 4, 1);
    bwr(0, O_E, 1);                                          // c0
    chk("R6 baseline high", int'(pwm_out[0]), 1);
    bwr(0, O_M, 8);                                          // c1
    chk("R6 c1 low", int'(pwm_out[0]), 0);
    tick(); tick(); tick();                                  // c4
    chk("R6 old modulus kept", int'(pwm_out[0]), 1);
    bwr(0, O_D, 6);                                          // c5
    chk("R7 old duty in running period", int'(pwm_out[0]), 0);
    tick(); tick();                                          // c7
    chk("R7 c7 still old", int'(pwm_out[0]), 0);
    tick();                                                  // c8
    hi = 0;
    for (int k = 0; k < 8; k++) begin hi += int'(pwm_out[0]); tick(); end
    chk("R7 new duty high cycles", hi, 6);
    chk("R7 new modulus period", int'(pwm_out[0]), 1);       // c16
    bwr(0, O_E, 0);

    // R9: duty write on the boundary cycle
    setup(1, 0, 4, 1);
    bwr(1, O_E, 1);                                          // c0
    tick(); tick(); tick();                                  // c3
    bwr(1, O_D, 3);                                          // c4
    chk("R9 boundary start high", int'(pwm_out[1]), 1);
    tick();                                                  // c5
    chk("R9 old duty kept one more period", int'(pwm_out[1]), 0);
    tick(); tick(); tick(); tick(); tick();                  // c10
    chk("R9 new duty at next boundary", int'(pwm_out[1]), 1);
    tick();                                                  // c11
    chk("R9 new duty ends", int'(pwm_out[1]), 0);

    // R8: stop inside the high phase, restart with a fresh commit
    tick();                                                  // c12
    bwr(1, O_E, 0);
    chk("R8 immediate stop", int'(pwm_out[1]), 0);
    tick(); tick();
    chk("R8 stays low", int'(pwm_out[1]), 0);
    bwr(1, O_D, 1);
    chk("R8 stopped ignores commit", int'(pwm_out[1]), 0);
    bwr(1, O_E, 1);                                          // c0
    chk("R8 restart at count zero", int'(pwm_out[1]), 1);
    tick();
    chk("R8 restart uses fresh duty", int'(pwm_out[1]), 0);
    bwr(1, O_E, 0);

    // R10: two channels at once
    setup(0, 0, 4, 1);
    setup(2, 0, 2, 2);
    bwr(0, O_E, 1);
    bwr(2, O_E, 1);
    begin
      int h0, h2;
      h0 = 0; h2 = 0;
      for (int k = 0; k < 8; k++) begin
        h0 += int'(pwm_out[0]); h2 += int'(pwm_out[2]); tick();
      end
      chk("R10 channel 0 highs", h0, 2);
      chk("R10 channel 2 highs", h2, 8);
      chk("R10 idle channel", int'(pwm_out[1]), 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule